// File: doc/BRIEF.md
# Lockable Device Capability Register Group

This block holds the registers of one device-level extended capability in configuration space. It sits behind a dword-wide register window. Writes use a byte address and four byte enables. Reads are combinational from a separate read address. The first dword is a constant header. It carries the capability length, a revision number and a vendor identifier, all fixed by parameters at build time.

The writable contents are a 16-bit control register, an 8-bit status register, a single lock bit and a parameterised number of memory-range base registers. Each range base is split into a high dword and a low dword. Every register applies a per-bit write mask. Bits outside the mask always read back their reset value.

Status bits are raised by hardware event inputs and cleared by writing ones. Once software sets the lock bit it stays set. While it is set, the control register and all range bases refuse writes. Only a power-on reset clears the lock and the status bits.

Top module: `dvsec_dev_regs`

## Requirements
- R1: Reading word 0 (byte address 0x00) returns {length[11:0], revision[3:0], vendor[15:0]} in bits 31:20, 19:16 and 15:0. Writes to word 0 never change this value.
- R2: Word 1 (0x04) holds the control register in bits 15:0, and bits 31:16 read 0. A write with byte enable b set updates only the bits of byte b that are inside the mask 0x4FFD. All other control bits keep their reset value.
- R3: Word 2 (0x08) holds status in bits 3:0, and bits 31:4 read 0. A status bit is set on a cycle when its event input is high. It is cleared by writing 1 to it with byte enable 0 set. When an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: Word 3 (0x0C) bit 0 is the lock bit, and bits 31:1 read 0. Writing 1 with byte enable 0 set sets the lock. No later write clears it.
- R5: While the lock is set, writes to the control register and to every range base register leave them unchanged.
- R6: Range i has its low dword at 0x10+8i and its high dword at 0x14+8i. All 32 bits of the high dword are writable. In the low dword only bits 31:28 are writable, through byte enable 3. The other bits of the low dword read their reset value.
- R7: Power-on reset (por_n low) clears the lock bit and the status bits. It also returns control and the range bases to their reset values.
- R8: Words above the last range register read 0, and writes to them change nothing that can be read.
- R9: Status clearing and status events keep working while the lock is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte address; bits 1:0 are ignored |
| wr_be | input | 4 | Write byte enables |
| wr_data | input | 32 | Write data |
| status_set | input | 8 | Hardware event inputs that set status bits |
| rd_addr | input | ADDR_W | Read byte address; bits 1:0 are ignored |
| rd_data | output | 32 | Read data for rd_addr, combinational |

## Verification
The checker assumes that por_n is asserted before the first clock edge. It also assumes that inputs change only away from the rising edge, so that one write is seen per strobed cycle.

The bench drives writes, events and read addresses only on falling edges. It holds por_n low for several cycles at start-up and again when it tests the cold reset.

The bench sweeps every word with every byte-enable pattern and several data patterns, first unlocked and then locked. It keeps the lock word out of the unlocked sweep, so that the lock is set exactly once and at a known point.

// File: rtl/dvsec_regs_pkg.sv
package dvsec_regs_pkg;

   // word slots inside the capability window
   localparam int unsigned WORD_HDR    = 0;
   localparam int unsigned WORD_CTRL   = 1;
   localparam int unsigned WORD_STAT   = 2;
   localparam int unsigned WORD_LOCK   = 3;
   localparam int unsigned WORD_RANGE0 = 4;

   // per-register write masks
   localparam logic [15:0] CTRL_WMASK    = 16'h4FFD;
   localparam logic [7:0]  STAT_WMASK    = 8'h0F;
   localparam logic [31:0] BASE_HI_WMASK = 32'hFFFF_FFFF;
   localparam logic [31:0] BASE_LO_WMASK = 32'hF000_0000;

   function automatic logic [31:0] pack_header(logic [11:0] len,
                                               logic [3:0]  rev,
                                               logic [15:0] vid);
      return {len, rev, vid};
   endfunction

endpackage

// File: rtl/dvsec_masked_reg.sv
module dvsec_masked_reg #(
   parameter int unsigned         BYTES = 4,
   parameter logic [BYTES*8-1:0]  MASK  = '1,
   parameter logic [BYTES*8-1:0]  RST   = '0
) (
   input  logic                 clk,
   input  logic                 por_n,
   input  logic                 wr_en,
   input  logic                 block,
   input  logic [BYTES-1:0]     wr_be,
   input  logic [BYTES*8-1:0]   wr_data,
   output logic [BYTES*8-1:0]   q
);

   generate
      if (BYTES < 1 || BYTES > 4) begin : g_bad_bytes
         $error("dvsec_masked_reg: BYTES must be 1..4");
      end
   endgenerate

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      localparam logic [7:0] LMASK = MASK[b*8 +: 8];
      localparam logic [7:0] LRST  = RST[b*8 +: 8];
      logic [7:0] lane_q;

      if (LMASK == 8'h00) begin : g_const
         // lane has no writable bit: pure constant
         assign lane_q = LRST;
      end else begin : g_store
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)
               lane_q <= LRST;
            else if (wr_en && wr_be[b] && !block)
               lane_q <= (lane_q & ~LMASK) | (wr_data[b*8 +: 8] & LMASK);
         end
      end

      assign q[b*8 +: 8] = lane_q;
   end

endmodule

// File: rtl/dvsec_sticky_status.sv
module dvsec_sticky_status #(
   parameter int unsigned     W    = 8,
   parameter logic [W-1:0]    MASK = '1
) (
   input  logic           clk,
   input  logic           por_n,
   input  logic [W-1:0]   set,
   input  logic           clr_en,
   input  logic [W-1:0]   clr_bits,
   output logic [W-1:0]   q
);

   logic [W-1:0] clr_eff;
   logic [W-1:0] q_r;

   assign clr_eff = clr_en ? clr_bits : '0;

   // an event in the same cycle as a clear wins
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         q_r <= '0;
      else
         q_r <= ((q_r & ~clr_eff) | set) & MASK;
   end

   assign q = q_r;

endmodule

// File: rtl/dvsec_once_bit.sv
module dvsec_once_bit (
   input  logic clk,
   input  logic por_n,
   input  logic wr_en,
   input  logic wr_bit,
   output logic q
);

   logic q_r;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         q_r <= 1'b0;
      else if (wr_en && wr_bit)
         q_r <= 1'b1;
   end

   assign q = q_r;

endmodule

// File: rtl/dvsec_dev_regs.sv
module dvsec_dev_regs
   import dvsec_regs_pkg::*;
#(
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned NUM_RANGES  = 2,
   parameter int unsigned CAP_LEN     = 12'h038,
   parameter int unsigned CAP_REV     = 1,
   parameter logic [15:0] VENDOR_ID   = 16'hC0DE,
   parameter logic [15:0] CTRL_RST    = 16'h0002,
   parameter logic [31:0] BASE_LO_RST = 32'h0000_0003
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [3:0]         wr_be,
   input  logic [31:0]        wr_data,
   input  logic [7:0]         status_set,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [31:0]        rd_data
);

   localparam int unsigned WORD_W    = ADDR_W - 2;
   localparam int unsigned NUM_WORDS = 1 << WORD_W;
   localparam int unsigned USED      = WORD_RANGE0 + 2 * NUM_RANGES;
   localparam logic [31:0] HEADER    =
      pack_header(CAP_LEN[11:0], CAP_REV[3:0], VENDOR_ID);

   generate
      if (CAP_LEN > 4095) begin : g_bad_len
         $error("dvsec_dev_regs: CAP_LEN exceeds 12 bits");
      end
      if (CAP_REV > 15) begin : g_bad_rev
         $error("dvsec_dev_regs: CAP_REV exceeds 4 bits");
      end
      if (ADDR_W < 3) begin : g_bad_aw
         $error("dvsec_dev_regs: ADDR_W too small");
      end
      if (USED > NUM_WORDS) begin : g_bad_fit
         $error("dvsec_dev_regs: ranges do not fit the window");
      end
   endgenerate

   logic [WORD_W-1:0] wr_word;
   logic [WORD_W-1:0] rd_word;
   logic [NUM_WORDS-1:0] wr_hit;

   assign wr_word = wr_addr[ADDR_W-1:2];
   assign rd_word = rd_addr[ADDR_W-1:2];

   for (genvar k = 0; k < NUM_WORDS; k++) begin : g_dec
      assign wr_hit[k] = wr_en && (wr_word == WORD_W'(k));
   end

   logic        lock_q;
   logic [15:0] ctrl_q;
   logic [7:0]  status_q;
   logic [NUM_RANGES*32-1:0] lo_flat;
   logic [NUM_RANGES*32-1:0] hi_flat;

   dvsec_once_bit u_lock (
      .clk    (clk),
      .por_n  (por_n),
      .wr_en  (wr_hit[WORD_LOCK] && wr_be[0]),
      .wr_bit (wr_data[0]),
      .q      (lock_q)
   );

   dvsec_masked_reg #(
      .BYTES (2),
      .MASK  (CTRL_WMASK),
      .RST   (CTRL_RST)
   ) u_ctrl (
      .clk     (clk),
      .por_n   (por_n),
      .wr_en   (wr_hit[WORD_CTRL]),
      .block   (lock_q),
      .wr_be   (wr_be[1:0]),
      .wr_data (wr_data[15:0]),
      .q       (ctrl_q)
   );

   dvsec_sticky_status #(
      .W    (8),
      .MASK (STAT_WMASK)
   ) u_status (
      .clk      (clk),
      .por_n    (por_n),
      .set      (status_set),
      .clr_en   (wr_hit[WORD_STAT] && wr_be[0]),
      .clr_bits (wr_data[7:0]),
      .q        (status_q)
   );

   for (genvar r = 0; r < NUM_RANGES; r++) begin : g_range
      localparam int unsigned LO_W = WORD_RANGE0 + 2 * r;
      localparam int unsigned HI_W = LO_W + 1;

      dvsec_masked_reg #(
         .BYTES (4),
         .MASK  (BASE_LO_WMASK),
         .RST   (BASE_LO_RST)
      ) u_lo (
         .clk     (clk),
         .por_n   (por_n),
         .wr_en   (wr_hit[LO_W]),
         .block   (lock_q),
         .wr_be   (wr_be),
         .wr_data (wr_data),
         .q       (lo_flat[r*32 +: 32])
      );

      dvsec_masked_reg #(
         .BYTES (4),
         .MASK  (BASE_HI_WMASK),
         .RST   (32'h0)
      ) u_hi (
         .clk     (clk),
         .por_n   (por_n),
         .wr_en   (wr_hit[HI_W]),
         .block   (lock_q),
         .wr_be   (wr_be),
         .wr_data (wr_data),
         .q       (hi_flat[r*32 +: 32])
      );
   end

   always_comb begin
      rd_data = '0;
      case (rd_word)
         WORD_W'(WORD_HDR):  rd_data = HEADER;
         WORD_W'(WORD_CTRL): rd_data = {16'h0, ctrl_q};
         WORD_W'(WORD_STAT): rd_data = {24'h0, status_q};
         WORD_W'(WORD_LOCK): rd_data = {31'h0, lock_q};
         default: begin
            for (int r = 0; r < NUM_RANGES; r++) begin
               if (rd_word == WORD_W'(WORD_RANGE0 + 2 * r))
                  rd_data = lo_flat[r*32 +: 32];
               if (rd_word == WORD_W'(WORD_RANGE0 + 2 * r + 1))
                  rd_data = hi_flat[r*32 +: 32];
            end
         end
      endcase
   end

endmodule

// File: rtl/dvsec_dev_regs_chk.sv
module dvsec_dev_regs_chk
   import dvsec_regs_pkg::*;
#(
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned NUM_RANGES  = 2,
   parameter logic [31:0] HEADER      = 32'h0,
   parameter logic [15:0] CTRL_RST    = 16'h0,
   parameter logic [31:0] BASE_LO_RST = 32'h0
) (
   input logic                       clk,
   input logic                       por_n,
   input logic [7:0]                 status_set,
   input logic                       lock_q,
   input logic [15:0]                ctrl_q,
   input logic [7:0]                 status_q,
   input logic [NUM_RANGES*32-1:0]   lo_flat,
   input logic [NUM_RANGES*32-1:0]   hi_flat,
   input logic [ADDR_W-1:0]          rd_addr,
   input logic [31:0]                rd_data
);

   localparam int unsigned USED = WORD_RANGE0 + 2 * NUM_RANGES;

   // R4
   lock_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      lock_q |=> lock_q);

   // R5
   ctrl_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
      lock_q |=> $stable(ctrl_q));

   // R5
   range_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
      lock_q |=> ($stable(lo_flat) && $stable(hi_flat)));

   // R3
   status_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
      (status_set == 8'h0) |=> ((status_q & ~$past(status_q)) == 8'h0));

   // R1
   header_chk: assert property (@(posedge clk) disable iff (!por_n)
      (rd_addr[ADDR_W-1:2] == '0) |-> (rd_data == HEADER));

   // R2
   ctrl_ro_chk: assert property (@(posedge clk) disable iff (!por_n)
      (ctrl_q & ~CTRL_WMASK) == (CTRL_RST & ~CTRL_WMASK));

   // R6
   lo_ro_chk: assert property (@(posedge clk) disable iff (!por_n)
      (lo_flat[31:0] & ~BASE_LO_WMASK) == (BASE_LO_RST & ~BASE_LO_WMASK));

   // R8
   unmapped_chk: assert property (@(posedge clk) disable iff (!por_n)
      (32'(rd_addr[ADDR_W-1:2]) >= USED) |-> (rd_data == 32'h0));

endmodule

bind dvsec_dev_regs dvsec_dev_regs_chk #(
   .ADDR_W      (ADDR_W),
   .NUM_RANGES  (NUM_RANGES),
   .HEADER      (HEADER),
   .CTRL_RST    (CTRL_RST),
   .BASE_LO_RST (BASE_LO_RST)
) u_chk (
   .clk        (clk),
   .por_n      (por_n),
   .status_set (status_set),
   .lock_q     (lock_q),
   .ctrl_q     (ctrl_q),
   .status_q   (status_q),
   .lo_flat    (lo_flat),
   .hi_flat    (hi_flat),
   .rd_addr    (rd_addr),
   .rd_data    (rd_data)
);

// File: tb/dvsec_dev_regs_test.sv
module dvsec_dev_regs_test;

   localparam int AW = 6;
   localparam int NR = 2;
   localparam logic [31:0] HDR     = 32'h0381_C0DE;
   localparam logic [15:0] C_RST   = 16'h0002;
   localparam logic [31:0] LO_RST  = 32'h0000_0003;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [3:0]    wr_be = '0;
   logic [31:0]   wr_data = '0;
   logic [7:0]    status_set = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [31:0]   rd_data;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // bench model
   logic [15:0] m_ctrl;
   logic [7:0]  m_stat;
   logic        m_lock;
   logic [31:0] m_lo [NR];
   logic [31:0] m_hi [NR];

   always #4 clk = ~clk;

   dvsec_dev_regs uut (
      .clk        (clk),
      .por_n      (por_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_be      (wr_be),
      .wr_data    (wr_data),
      .status_set (status_set),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data)
   );

   function automatic logic [31:0] bmask(logic [3:0] be);
      return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   endfunction

   task automatic model_reset();
      m_ctrl = C_RST;
      m_stat = 8'h0;
      m_lock = 1'b0;
      for (int i = 0; i < NR; i++) begin
         m_lo[i] = LO_RST;
         m_hi[i] = 32'h0;
      end
   endtask

   function automatic logic [31:0] expect_word(int w);
      if (w == 0) return HDR;
      if (w == 1) return {16'h0, m_ctrl};
      if (w == 2) return {24'h0, m_stat};
      if (w == 3) return {31'h0, m_lock};
      if (w >= 4 && w < 4 + 2 * NR) begin
         if (w % 2 == 0) return m_lo[(w - 4) / 2];
         return m_hi[(w - 4) / 2];
      end
      return 32'h0;
   endfunction

   function automatic string tag_of(int w);
      if (w == 0) return "R1";
      if (w == 1) return "R2";
      if (w == 2) return "R3";
      if (w == 3) return "R4";
      if (w < 4 + 2 * NR) return "R6";
      return "R8";
   endfunction

   task automatic check_word(int w, string ctx);
      logic [31:0] e;
      @(negedge clk);
      rd_addr = AW'(w * 4);
      #1;
      e = expect_word(w);
      checks++;
      if (rd_data !== e) begin
         errors++;
         $display("FAIL %s/%s word %0d: actual=%08h expected=%08h",
                  tag_of(w), ctx, w, rd_data, e);
      end
   endtask

   task automatic check_all(string ctx);
      for (int w = 0; w < 16; w++) check_word(w, ctx);
   endtask

   // model update for one write (R2..R6, R8)
   task automatic model_write(int w, logic [31:0] d, logic [3:0] be);
      logic [31:0] m;
      m = bmask(be);
      if (w == 1 && !m_lock)
         m_ctrl = (m_ctrl & ~(m[15:0] & 16'h4FFD)) | (d[15:0] & m[15:0] & 16'h4FFD);
      if (w == 2 && be[0])
         m_stat = m_stat & ~(d[7:0] & 8'h0F);
      if (w == 3 && be[0] && d[0])
         m_lock = 1'b1;
      if (w >= 4 && w < 4 + 2 * NR && !m_lock) begin
         if (w % 2 == 0)
            m_lo[(w-4)/2] = (m_lo[(w-4)/2] & ~(m & 32'hF000_0000)) | (d & m & 32'hF000_0000);
         else
            m_hi[(w-4)/2] = (m_hi[(w-4)/2] & ~m) | (d & m);
      end
   endtask

   task automatic do_write(int w, logic [31:0] d, logic [3:0] be, logic [7:0] ev);
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = AW'(w * 4 + 1);   // low address bits are ignored
      wr_be = be;
      wr_data = d;
      status_set = ev;
      @(negedge clk);
      wr_en = 1'b0;
      status_set = 8'h0;
      model_write(w, d, be);
      m_stat = m_stat | (ev & 8'h0F);   // event wins over clear
   endtask

   task automatic do_event(logic [7:0] ev);
      @(negedge clk);
      status_set = ev;
      @(negedge clk);
      status_set = 8'h0;
      m_stat = m_stat | (ev & 8'h0F);
   endtask

   task automatic sweep(string ctx, bit skip_lock);
      logic [31:0] pats [4];
      pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000;
      pats[2] = 32'hA5A5_A5A5; pats[3] = 32'h5A5A_5A5A;
      for (int w = 0; w < 16; w++) begin
         if (!(skip_lock && w == 3)) begin
            do_event(8'hF5);
            for (int p = 0; p < 4; p++)
               for (int be = 0; be < 16; be++) begin
                  do_write(w, pats[p] ^ (32'(be) << 8), 4'(be), 8'h0);
                  check_word(w, ctx);
               end
            check_all(ctx);
         end
      end
   endtask

   initial begin
      model_reset();
      repeat (4) @(negedge clk);
      por_n = 1'b1;
      // reset state: R1 R2 R3 R4 R6 R8
      check_all("reset");

      // R2 R3 R6 R8: unlocked sweep, lock word kept aside
      sweep("unlocked", 1'b1);

      // R3: event and clear on the same bit in the same cycle
      do_event(8'h01);
      do_write(2, 32'h0000_0001, 4'h1, 8'h01);
      check_word(2, "R3 set-wins");
      do_write(2, 32'h0000_000F, 4'h1, 8'h00);
      check_word(2, "R3 clear");

      // R4: lock write without byte enable 0 does nothing
      do_write(3, 32'h0000_0001, 4'hE, 8'h00);
      check_word(3, "R4 no-be");
      // set known values, then lock
      do_write(1, 32'h0000_4321, 4'h3, 8'h00);
      do_write(4, 32'hB000_0000, 4'hF, 8'h00);
      do_write(5, 32'h1234_5678, 4'hF, 8'h00);
      do_write(3, 32'h0000_0001, 4'h1, 8'h00);
      check_all("R4 locked");
      // R4: clearing attempt
      do_write(3, 32'h0000_0000, 4'hF, 8'h00);
      check_word(3, "R4 hold");

      // R5 R9: locked sweep over everything
      sweep("R5 R9 locked", 1'b0);
      do_event(8'h0A);
      check_word(2, "R9 event");
      do_write(2, 32'h0000_0008, 4'h1, 8'h00);
      check_word(2, "R9 clear");

      // R7: cold reset clears lock, status and restores defaults
      do_event(8'h0F);
      @(negedge clk);
      por_n = 1'b0;
      repeat (2) @(negedge clk);
      por_n = 1'b1;
      model_reset();
      check_all("R7 cold");
      do_write(1, 32'h0000_FFFF, 4'h3, 8'h00);
      check_word(1, "R7 unlocked");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule